// File: doc/BRIEF.md
# CAN Controller Mode and Status Sequencer

This block is the mode-control and register front end of a CAN controller. It accepts 32-bit register writes from a simple bus and holds the controller's operating mode. The modes are configuration, normal, loopback, snoop and sleep. The active mode is reported as a single set bit in a status word. Two interrupt flags, one for transmit done and one for receive done, are cleared by writing ones to a clear register. The block also holds the frame to transmit, a set of received-frame registers, and a timestamp counter that tags every frame taken from the bus.

The rest of the controller sees only frame-level strobes:
- In normal mode, a transmit request pulse goes out together with the four frame words, and the bus answers with a done pulse.
- A start-of-frame strobe marks activity from another node.
- A valid strobe delivers a complete received frame with its four words.

Bit timing, arbitration, CRC and the line interface sit elsewhere.

Software clears the enable bit, chooses a mode, and then sets the enable bit. While the controller is enabled, the mode selector is locked. A node in sleep returns to normal as soon as the bus shows activity. In loopback, a frame that software starts is copied straight into the block's own receive registers.

Top module: `can_mode_seq`

## Requirements
- R1: After reset the controller is in configuration mode. The status word reads 0x0000_0001, the interrupt status reads 0, the enable register reads 0, and `tx_req_o` is low.
- R2: Bit 1 of the enable register (offset 0x00) controls operation. Writing it as 1 while in configuration mode enters the mode held in the selector. Writing it as 0 returns the controller to configuration mode from any mode.
- R3: The selector (offset 0x04) uses 0x0 for normal, 0x1 for sleep, 0x2 for loopback and 0x4 for snoop. The status word (offset 0x18) has exactly one bit set: bit 3 for normal, bit 1 for loopback, bit 2 for sleep, bit 12 for snoop, and bit 0 for configuration.
- R4: A selector write made while the controller is enabled is ignored. Both the selector readback and the status word stay unchanged.
- R5: The transmit frame registers are at 0x30 (ID), 0x34 (length), 0x38 (data 1) and 0x3C (data 2). In normal mode, a write to 0x3C makes `tx_req_o` pulse for one cycle with the four words on the `tx_*_o` outputs. Interrupt status bit 1 is set only when `tx_done_i` arrives for that pending request. A `tx_done_i` pulse with no request pending has no effect.
- R6: Interrupt status (offset 0x1C) uses bit 1 for transmit done and bit 4 for receive done. Writing a 1 to the same bit of the clear register (offset 0x24) clears only that flag. A flag that is set in the same cycle as it is cleared stays set.
- R7: In loopback mode, a write to 0x3C places the frame in the receive registers (0x50 ID, 0x54 length, 0x58 data 1, 0x5C data 2) with its length word unchanged. It also sets both interrupt flags and does not pulse `tx_req_o`. Frames arriving from the bus are ignored in this mode.
- R8: In normal, snoop and sleep modes, a frame from the bus is stored in the receive registers and sets receive done. Its length word is stored as the bus length plus a timestamp count. The count advances by one per stored bus frame, so the first such frame adds 1.
- R9: In sleep mode, a start-of-frame strobe or a received frame moves the controller to normal mode. A frame that causes the wake-up is still stored.
- R10: In snoop mode, a write to 0x3C never pulses `tx_req_o` and never sets transmit done. The controller still receives bus frames.
- R11: In configuration mode, bus frames are not stored and do not advance the timestamp, and a write to 0x3C starts no transmission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr_i | input | 1 | Register write strobe |
| reg_waddr_i | input | 8 | Write byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_raddr_i | input | 8 | Read byte offset |
| reg_rdata_o | output | 32 | Read data for `reg_raddr_i` (combinational) |
| tx_req_o | output | 1 | One-cycle transmit request |
| tx_id_o | output | 32 | Transmit ID word |
| tx_len_o | output | 32 | Transmit length word |
| tx_d1_o | output | 32 | Transmit data word 1 |
| tx_d2_o | output | 32 | Transmit data word 2 |
| tx_done_i | input | 1 | Bus reports the requested frame as sent |
| bus_sof_i | input | 1 | Start of a frame from another node seen on the bus |
| bus_rx_valid_i | input | 1 | A complete frame from the bus is presented |
| bus_rx_id_i | input | 32 | Received ID word |
| bus_rx_len_i | input | 32 | Received length word, before timestamping |
| bus_rx_d1_i | input | 32 | Received data word 1 |
| bus_rx_d2_i | input | 32 | Received data word 2 |

## Verification
The hardest states to reach are the ones where a frame counts only because of the current mode. These are a wake-up from sleep in which the waking frame must still be stored, and a timestamp that must skip every frame dropped while in configuration or loopback. The stimulus drives a single, ordered session that passes through every mode. Bus frames are injected in the modes that ignore them as well as in those that accept them. As a result, the expected timestamp at each later capture depends on every earlier acceptance decision having been correct. The bench also injects an unsolicited `tx_done_i` and makes selector writes while the controller is enabled, then reads back through the register port that nothing changed.

// File: rtl/can_ms_pkg.sv
package can_ms_pkg;

  localparam int unsigned REG_W   = 32;
  localparam int unsigned OFS_W   = 8;

  // Register offsets (byte addresses)
  localparam logic [OFS_W-1:0] OFS_ENA   = 8'h00;
  localparam logic [OFS_W-1:0] OFS_SEL   = 8'h04;
  localparam logic [OFS_W-1:0] OFS_STAT  = 8'h18;
  localparam logic [OFS_W-1:0] OFS_IRQ   = 8'h1C;
  localparam logic [OFS_W-1:0] OFS_ICLR  = 8'h24;
  localparam logic [OFS_W-1:0] OFS_TXID  = 8'h30;
  localparam logic [OFS_W-1:0] OFS_TXLEN = 8'h34;
  localparam logic [OFS_W-1:0] OFS_TXD1  = 8'h38;
  localparam logic [OFS_W-1:0] OFS_TXD2  = 8'h3C;
  localparam logic [OFS_W-1:0] OFS_RXID  = 8'h50;
  localparam logic [OFS_W-1:0] OFS_RXLEN = 8'h54;
  localparam logic [OFS_W-1:0] OFS_RXD1  = 8'h58;
  localparam logic [OFS_W-1:0] OFS_RXD2  = 8'h5C;

  // Bit positions
  localparam int unsigned ENA_BIT      = 1;
  localparam int unsigned IRQ_TX_BIT   = 1;
  localparam int unsigned IRQ_RX_BIT   = 4;
  localparam int unsigned ST_CFG_BIT   = 0;
  localparam int unsigned ST_LOOP_BIT  = 1;
  localparam int unsigned ST_SLEEP_BIT = 2;
  localparam int unsigned ST_NORM_BIT  = 3;
  localparam int unsigned ST_SNOOP_BIT = 12;

  localparam int unsigned SEL_W = 3;
  localparam int unsigned N_IRQ = 2;
  localparam int unsigned IRQ_TX_IDX = 0;
  localparam int unsigned IRQ_RX_IDX = 1;

  typedef enum logic [2:0] {
    OPM_CFG    = 3'd0,
    OPM_NORMAL = 3'd1,
    OPM_LOOP   = 3'd2,
    OPM_SNOOP  = 3'd3,
    OPM_SLEEP  = 3'd4
  } opmode_e;

  typedef struct packed {
    logic [REG_W-1:0] id;
    logic [REG_W-1:0] len;
    logic [REG_W-1:0] d1;
    logic [REG_W-1:0] d2;
  } frame_t;

  function automatic opmode_e sel_to_mode(input logic [SEL_W-1:0] sel);
    if (sel[1])      return OPM_LOOP;
    else if (sel[0]) return OPM_SLEEP;
    else if (sel[2]) return OPM_SNOOP;
    else             return OPM_NORMAL;
  endfunction

  function automatic logic [REG_W-1:0] mode_to_status(input opmode_e m);
    logic [REG_W-1:0] s;
    s = '0;
    case (m)
      OPM_NORMAL: s[ST_NORM_BIT]  = 1'b1;
      OPM_LOOP:   s[ST_LOOP_BIT]  = 1'b1;
      OPM_SNOOP:  s[ST_SNOOP_BIT] = 1'b1;
      OPM_SLEEP:  s[ST_SLEEP_BIT] = 1'b1;
      default:    s[ST_CFG_BIT]   = 1'b1;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/can_ms_mode_ctl.sv
module can_ms_mode_ctl
  import can_ms_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ena_wr_i,
  input  logic             ena_bit_i,
  input  logic             sel_wr_i,
  input  logic [SEL_W-1:0] sel_wdata_i,
  input  logic             wake_i,
  output opmode_e          mode_o,
  output logic [SEL_W-1:0] sel_o
);

  opmode_e          mode_q, mode_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             mode_en, sel_en;

  always_comb begin
    mode_d = mode_q;
    if (ena_wr_i) begin
      if (!ena_bit_i)
        mode_d = OPM_CFG;
      else if (mode_q == OPM_CFG)
        mode_d = sel_to_mode(sel_q);
    end else if (mode_q == OPM_SLEEP && wake_i) begin
      mode_d = OPM_NORMAL;
    end
  end

  assign mode_en = (mode_d != mode_q);
  assign sel_en  = sel_wr_i && (mode_q == OPM_CFG);
  assign sel_d   = sel_wdata_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= OPM_CFG;
    else if (mode_en) mode_q <= mode_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_en) sel_q <= sel_d;
  end

  assign mode_o = mode_q;
  assign sel_o  = sel_q;

  // R4
  sel_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_wr_i && mode_q != OPM_CFG) |=> $stable(sel_q));

  // R2
  disable_to_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_wr_i && !ena_bit_i) |=> (mode_q == OPM_CFG));

  // R9
  sleep_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == OPM_SLEEP && wake_i && !ena_wr_i) |=> (mode_q == OPM_NORMAL));

endmodule

// File: rtl/can_ms_irq.sv
module can_ms_irq
  import can_ms_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] set_i,
  input  logic [N_IRQ-1:0] clr_i,
  output logic [N_IRQ-1:0] flags_o
);

  logic [N_IRQ-1:0] flag_q;

  for (genvar g = 0; g < N_IRQ; g++) begin : g_flag
    logic flag_d, flag_en;
    assign flag_en = set_i[g] | clr_i[g];
    assign flag_d  = set_i[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q[g] <= 1'b0;
      else if (flag_en) flag_q[g] <= flag_d;
    end

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> flag_q[g]);

    // R6
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !set_i[g]) |=> !flag_q[g]);
  end

  assign flags_o = flag_q;

endmodule

// File: rtl/can_ms_rx_hold.sv
module can_ms_rx_hold
  import can_ms_pkg::*;
#(
  parameter int unsigned TS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lb_take_i,
  input  frame_t          lb_frame_i,
  input  logic            bus_take_i,
  input  frame_t          bus_frame_i,
  output frame_t          rx_o
);

  localparam int unsigned PAD_W = REG_W - TS_W;

  frame_t          rx_q, rx_d;
  logic [TS_W-1:0] ts_q, ts_inc;
  logic            rx_en, ts_en;

  assign ts_inc = ts_q + {{(TS_W-1){1'b0}}, 1'b1};
  assign ts_en  = bus_take_i && !lb_take_i;
  assign rx_en  = lb_take_i || bus_take_i;

  always_comb begin
    if (lb_take_i) begin
      rx_d = lb_frame_i;
    end else begin
      rx_d     = bus_frame_i;
      rx_d.len = bus_frame_i.len + {{PAD_W{1'b0}}, ts_inc};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ts_q <= '0;
    else if (ts_en) ts_q <= ts_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rx_q <= '0;
    else if (rx_en) rx_q <= rx_d;
  end

  assign rx_o = rx_q;

  // R8
  ts_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ts_en |=> (ts_q == $past(ts_q) + TS_W'(1)));

  // R7
  lb_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lb_take_i |=> (rx_q.len == $past(lb_frame_i.len) && ts_q == $past(ts_q)));

endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
  import can_ms_pkg::*;
#(
  parameter int unsigned TS_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_i,
  input  logic [7:0]  reg_waddr_i,
  input  logic [31:0] reg_wdata_i,
  input  logic [7:0]  reg_raddr_i,
  output logic [31:0] reg_rdata_o,
  output logic        tx_req_o,
  output logic [31:0] tx_id_o,
  output logic [31:0] tx_len_o,
  output logic [31:0] tx_d1_o,
  output logic [31:0] tx_d2_o,
  input  logic        tx_done_i,
  input  logic        bus_sof_i,
  input  logic        bus_rx_valid_i,
  input  logic [31:0] bus_rx_id_i,
  input  logic [31:0] bus_rx_len_i,
  input  logic [31:0] bus_rx_d1_i,
  input  logic [31:0] bus_rx_d2_i
);

  localparam int unsigned SYNC_N = 2;

  // reset: asserted asynchronously, released on the clock
  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[SYNC_N-1];

  // write decode
  logic wr_ena, wr_sel, wr_iclr, wr_id, wr_len, wr_d1, wr_d2;
  assign wr_ena  = reg_wr_i && (reg_waddr_i == OFS_ENA);
  assign wr_sel  = reg_wr_i && (reg_waddr_i == OFS_SEL);
  assign wr_iclr = reg_wr_i && (reg_waddr_i == OFS_ICLR);
  assign wr_id   = reg_wr_i && (reg_waddr_i == OFS_TXID);
  assign wr_len  = reg_wr_i && (reg_waddr_i == OFS_TXLEN);
  assign wr_d1   = reg_wr_i && (reg_waddr_i == OFS_TXD1);
  assign wr_d2   = reg_wr_i && (reg_waddr_i == OFS_TXD2);

  // mode control
  opmode_e          mode;
  logic [SEL_W-1:0] sel;

  can_ms_mode_ctl u_mode (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .ena_wr_i    (wr_ena),
    .ena_bit_i   (reg_wdata_i[ENA_BIT]),
    .sel_wr_i    (wr_sel),
    .sel_wdata_i (reg_wdata_i[SEL_W-1:0]),
    .wake_i      (bus_sof_i | bus_rx_valid_i),
    .mode_o      (mode),
    .sel_o       (sel)
  );

  // transmit frame registers
  frame_t tx_q;
  logic   tx_start, start_norm, lb_take;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)     tx_q.id <= '0;
    else if (wr_id)   tx_q.id <= reg_wdata_i;
  end
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)     tx_q.len <= '0;
    else if (wr_len)  tx_q.len <= reg_wdata_i;
  end
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)     tx_q.d1 <= '0;
    else if (wr_d1)   tx_q.d1 <= reg_wdata_i;
  end
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)     tx_q.d2 <= '0;
    else if (wr_d2)   tx_q.d2 <= reg_wdata_i;
  end

  assign tx_start   = wr_d2 && (mode == OPM_NORMAL || mode == OPM_LOOP);
  assign start_norm = tx_start && (mode == OPM_NORMAL);
  assign lb_take    = tx_start && (mode == OPM_LOOP);

  // request pulse and pending flag
  logic tx_req_q, busy_q, busy_d, busy_en;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) tx_req_q <= 1'b0;
    else          tx_req_q <= start_norm;
  end

  assign busy_en = start_norm | tx_done_i;
  assign busy_d  = start_norm;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)     busy_q <= 1'b0;
    else if (busy_en) busy_q <= busy_d;
  end

  assign tx_req_o = tx_req_q;
  assign tx_id_o  = tx_q.id;
  assign tx_len_o = tx_q.len;
  assign tx_d1_o  = tx_q.d1;
  assign tx_d2_o  = tx_q.d2;

  // receive path
  frame_t lb_frame, bus_frame, rx;
  logic   bus_take;

  always_comb begin
    lb_frame    = tx_q;
    lb_frame.d2 = reg_wdata_i;
  end

  assign bus_frame = '{id: bus_rx_id_i, len: bus_rx_len_i,
                       d1: bus_rx_d1_i, d2: bus_rx_d2_i};
  assign bus_take  = bus_rx_valid_i &&
                     (mode == OPM_NORMAL || mode == OPM_SNOOP || mode == OPM_SLEEP);

  can_ms_rx_hold #(.TS_W(TS_W)) u_rx (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .lb_take_i   (lb_take),
    .lb_frame_i  (lb_frame),
    .bus_take_i  (bus_take),
    .bus_frame_i (bus_frame),
    .rx_o        (rx)
  );

  // interrupt flags
  logic [N_IRQ-1:0] irq_set, irq_clr, irq_flags;

  assign irq_set[IRQ_TX_IDX] = (busy_q && tx_done_i) || lb_take;
  assign irq_set[IRQ_RX_IDX] = bus_take || lb_take;
  assign irq_clr[IRQ_TX_IDX] = wr_iclr && reg_wdata_i[IRQ_TX_BIT];
  assign irq_clr[IRQ_RX_IDX] = wr_iclr && reg_wdata_i[IRQ_RX_BIT];

  can_ms_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .set_i   (irq_set),
    .clr_i   (irq_clr),
    .flags_o (irq_flags)
  );

  // read mux
  logic [REG_W-1:0] status_w, irq_w, ena_w;

  assign status_w = mode_to_status(mode);

  always_comb begin
    irq_w = '0;
    irq_w[IRQ_TX_BIT] = irq_flags[IRQ_TX_IDX];
    irq_w[IRQ_RX_BIT] = irq_flags[IRQ_RX_IDX];
    ena_w = '0;
    ena_w[ENA_BIT] = (mode != OPM_CFG);
  end

  always_comb begin
    case (reg_raddr_i)
      OFS_ENA:   reg_rdata_o = ena_w;
      OFS_SEL:   reg_rdata_o = {{(REG_W-SEL_W){1'b0}}, sel};
      OFS_STAT:  reg_rdata_o = status_w;
      OFS_IRQ:   reg_rdata_o = irq_w;
      OFS_TXID:  reg_rdata_o = tx_q.id;
      OFS_TXLEN: reg_rdata_o = tx_q.len;
      OFS_TXD1:  reg_rdata_o = tx_q.d1;
      OFS_TXD2:  reg_rdata_o = tx_q.d2;
      OFS_RXID:  reg_rdata_o = rx.id;
      OFS_RXLEN: reg_rdata_o = rx.len;
      OFS_RXD1:  reg_rdata_o = rx.d1;
      OFS_RXD2:  reg_rdata_o = rx.d2;
      default:   reg_rdata_o = '0;
    endcase
  end

  // R3
  status_onehot_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    $countones(status_w) == 1);

  // R10
  snoop_silent_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mode == OPM_SNOOP) |=> (!tx_req_o && !($rose(irq_flags[IRQ_TX_IDX]))));

  // R11
  cfg_no_tx_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mode == OPM_CFG) |=> !tx_req_o);

endmodule

// File: tb/can_mode_seq_tb.sv
`timescale 1ns/1ps
module can_mode_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [7:0]  waddr, raddr;
  logic [31:0] wdata, rdata;
  logic        tx_req;
  logic [31:0] tx_id, tx_len, tx_d1, tx_d2;
  logic        tx_done, sof, rx_valid;
  logic [31:0] rx_id, rx_len, rx_d1, rx_d2;

  int n_chk  = 0;
  int n_fail = 0;
  logic [127:0] exp_q[$];

  always #2 clk = ~clk;

  can_mode_seq dut_i (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_i(reg_wr), .reg_waddr_i(waddr), .reg_wdata_i(wdata),
    .reg_raddr_i(raddr), .reg_rdata_o(rdata),
    .tx_req_o(tx_req), .tx_id_o(tx_id), .tx_len_o(tx_len),
    .tx_d1_o(tx_d1), .tx_d2_o(tx_d2), .tx_done_i(tx_done),
    .bus_sof_i(sof), .bus_rx_valid_i(rx_valid),
    .bus_rx_id_i(rx_id), .bus_rx_len_i(rx_len),
    .bus_rx_d1_i(rx_d1), .bus_rx_d2_i(rx_d2)
  );

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // monitor: every transmit request must match the next expected frame
  always @(negedge clk) begin
    if (rst_n && tx_req) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R5/R10/R11 unexpected tx_req got %h exp none",
                 {tx_id, tx_len, tx_d1, tx_d2});
      end else begin
        logic [127:0] e;
        e = exp_q.pop_front();
        if ({tx_id, tx_len, tx_d1, tx_d2} !== e) begin
          n_fail++;
          $display("FAIL R5 tx frame got %h exp %h", {tx_id, tx_len, tx_d1, tx_d2}, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired got running exp done");
    finish_run();
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; waddr = a; wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic chk(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    raddr = a;
    #1;
    n_chk++;
    if (rdata !== e) begin
      n_fail++;
      $display("FAIL %s addr %h got %h exp %h", tag, a, rdata, e);
    end
  endtask

  task automatic send_tx(input logic [31:0] i, l, a, b, input bit expect_req);
    wr(8'h30, i); wr(8'h34, l); wr(8'h38, a);
    if (expect_req) exp_q.push_back({i, l, a, b});
    wr(8'h3C, b);
  endtask

  task automatic bus_frame(input logic [31:0] i, l, a, b);
    @(negedge clk);
    rx_valid = 1'b1; rx_id = i; rx_len = l; rx_d1 = a; rx_d2 = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0;
  endtask

  task automatic set_mode(input logic [31:0] s);
    wr(8'h00, 32'h0);
    wr(8'h04, s);
    wr(8'h00, 32'h2);
  endtask

  task automatic chk_rx(input logic [31:0] i, l, a, b, input string tag);
    chk(8'h50, i, tag); chk(8'h54, l, tag);
    chk(8'h58, a, tag); chk(8'h5C, b, tag);
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; waddr = '0; wdata = '0; raddr = '0;
    tx_done = 1'b0; sof = 1'b0; rx_valid = 1'b0;
    rx_id = '0; rx_len = '0; rx_d1 = '0; rx_d2 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(8'h18, 32'h1, "R1 status");
    chk(8'h1C, 32'h0, "R1 irq");
    chk(8'h00, 32'h0, "R1 enable");
    n_chk++;
    if (tx_req !== 1'b0) begin n_fail++; $display("FAIL R1 tx_req got %b exp 0", tx_req); end

    // R2/R3 enter normal
    set_mode(32'h0);
    chk(8'h18, 32'h8, "R3 normal status");
    chk(8'h00, 32'h2, "R2 enable read");

    // R4 selector locked while enabled
    wr(8'h04, 32'h2);
    chk(8'h04, 32'h0, "R4 selector");
    chk(8'h18, 32'h8, "R4 status");

    // R5 transmit in normal
    send_tx(32'h0000_07A1, 32'h0000_0008, 32'hDEAD_BEEF, 32'h0BAD_F00D, 1'b1);
    chk(8'h1C, 32'h0, "R5 no done before ack");
    pulse_done();
    chk(8'h1C, 32'h2, "R5 done after ack");
    wr(8'h24, 32'h2);
    chk(8'h1C, 32'h0, "R6 clear tx flag");
    pulse_done();
    chk(8'h1C, 32'h0, "R5 stray ack ignored");

    // R8 receive in normal, timestamp 1 then 2
    bus_frame(32'h123, 32'h4, 32'hA1A1_A1A1, 32'hB2B2_B2B2);
    chk_rx(32'h123, 32'h5, 32'hA1A1_A1A1, 32'hB2B2_B2B2, "R8 first frame");
    chk(8'h1C, 32'h10, "R8 rx flag");
    bus_frame(32'h124, 32'h4, 32'h1, 32'h2);
    chk(8'h54, 32'h6, "R8 second timestamp");
    wr(8'h24, 32'h2);
    chk(8'h1C, 32'h10, "R6 clear only selected bit");
    wr(8'h24, 32'h10);
    chk(8'h1C, 32'h0, "R6 clear rx flag");

    // R2/R11 configuration ignores frames and transmit
    wr(8'h00, 32'h0);
    chk(8'h18, 32'h1, "R2 back to config");
    bus_frame(32'h777, 32'h9, 32'h9, 32'h9);
    chk(8'h50, 32'h124, "R11 frame ignored");
    chk(8'h1C, 32'h0, "R11 no rx flag");
    send_tx(32'h11, 32'h22, 32'h33, 32'h44, 1'b0);
    chk(8'h1C, 32'h0, "R11 no transmit");

    // R7 loopback
    wr(8'h04, 32'h2);
    wr(8'h00, 32'h2);
    chk(8'h18, 32'h2, "R3 loopback status");
    send_tx(32'h0000_0055, 32'h0000_0003, 32'hCAFE_0001, 32'hCAFE_0002, 1'b0);
    chk_rx(32'h55, 32'h3, 32'hCAFE_0001, 32'hCAFE_0002, "R7 loopback copy");
    chk(8'h1C, 32'h12, "R7 both flags");
    bus_frame(32'h999, 32'h1, 32'h1, 32'h1);
    chk(8'h50, 32'h55, "R7 bus frame ignored");
    wr(8'h24, 32'h12);

    // R10 snoop
    set_mode(32'h4);
    chk(8'h18, 32'h1000, "R3 snoop status");
    send_tx(32'h66, 32'h1, 32'h2, 32'h3, 1'b0);
    pulse_done();
    chk(8'h1C, 32'h0, "R10 no tx flag");
    bus_frame(32'h200, 32'h10, 32'h5, 32'h6);
    chk(8'h54, 32'h13, "R10 snoop receives, R8 timestamp 3");
    chk(8'h1C, 32'h10, "R10 rx flag");
    wr(8'h24, 32'h10);

    // R9 sleep wake by start of frame, then by a frame
    set_mode(32'h1);
    chk(8'h18, 32'h4, "R3 sleep status");
    @(negedge clk); sof = 1'b1;
    @(negedge clk); sof = 1'b0;
    chk(8'h18, 32'h8, "R9 woken by activity");
    set_mode(32'h1);
    chk(8'h18, 32'h4, "R9 asleep again");
    bus_frame(32'h300, 32'h20, 32'h7, 32'h8);
    chk(8'h18, 32'h8, "R9 woken by frame");
    chk(8'h54, 32'h24, "R9 waking frame stored");

    repeat (2) @(negedge clk);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R5 pending frames got %0d exp 0", exp_q.size());
    end
    finish_run();
  end

endmodule